// File: doc/BRIEF.md
# Viterbi Butterfly Add-Compare-Select Unit

This block advances the path metrics of a 64-state trellis for a rate-1/2 convolutional code with constraint length 7 (generator polynomials 171 and 133 in octal). Each accepted stage carries two signed soft symbols. The block turns them into branch costs. Thirty-two radix-2 butterflies then perform add-compare-select for all states in a single clock. The 64 survivor decisions of that stage are stored as one word in a history memory, at the address held by a stage counter. A later trace-back unit reads that memory back by stage index.

For tail-biting blocks the starting state is unknown. The user therefore pulses a start input, which sets every path metric to zero. The user then feeds the last 24 stages of the block as a pre-run, the whole block, and the first 24 stages again as a post-run. The final stage is marked. After it, the block reports the state that holds the smallest metric, which is where trace-back begins. Any metric can also be read out by state index.

Top module: `vit_acs_core`

## Requirements
- R1: After reset, all 64 path metrics read zero, best_valid_o is low and the stage counter is zero.
- R2: A cycle with start_i high sets all metrics to zero and the stage counter to zero, and clears best_valid_o. A symbol presented in that same cycle is dropped.
- R3: Soft symbols are signed two's complement, and negative values favour bit 0. The cost of one symbol s is s+8 when the expected bit is 0, and 7-s when it is 1. A branch costs the sum over both symbols. The expected bits for a transition from state p with input u come from the 7-bit register {p,u} (u in bit 0): sym0 pairs with the parity of {p,u}&171o, and sym1 pairs with the parity of {p,u}&133o.
- R4: New state j is reached from states j>>1 and (j>>1)+32 and keeps the smaller candidate sum. A tie goes to state j>>1. Decision bit j is 1 exactly when the survivor came from (j>>1)+32.
- R5: After the add-compare-select, if every one of the 64 new 10-bit metrics has bit 9 set, bit 9 is cleared in all of them in the same step.
- R6: In a cycle with neither sym_valid_i nor start_i high, the metrics, the stage counter and best_valid_o hold.
- R7: Each accepted stage writes its 64-bit decision word (bit j for state j) at the current stage counter, and the counter then increments, wrapping from 127 to 0. rd_data_o shows the word at rd_addr_i one clock after the address is applied.
- R8: best_valid_o rises after an accepted stage with last_i high, and falls after an accepted stage without it. best_state_o is the lowest state index holding the smallest metric.
- R9: Start from zero metrics and feed a noise-free tail-biting block with the 24-stage wrapped pre-run and post-run. The best state is then the encoder state after the first 24 information bits, with the newest bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Warm start: zero all metrics and the stage counter |
| sym_valid_i | input | 1 | One trellis stage is presented |
| last_i | input | 1 | Marks the final stage of a block |
| sym0_i | input | 4 | Signed soft symbol for the first code bit |
| sym1_i | input | 4 | Signed soft symbol for the second code bit |
| rd_addr_i | input | 7 | History read address (stage index) |
| rd_data_o | output | 64 | Decision word read back, one cycle latency |
| pm_sel_i | input | 6 | State whose metric is shown on pm_o |
| pm_o | output | 10 | Path metric of the selected state |
| best_state_o | output | 6 | Lowest index of the minimum metric |
| best_valid_o | output | 1 | Final stage done, best_state_o is meaningful |

## Verification
The hardest situation to reach from the ports is metric renormalisation. It only happens once all 64 metrics have crossed the upper half of their range together. Clean or lightly noisy blocks keep the correct path near zero, so they never get there. The stimulus therefore runs a long block of neutral symbols, where every branch costs 14 to 16. That raises all metrics in lockstep until the shared top bit is cleared. The same run goes past 128 stages, so the history address also wraps.

// File: rtl/vit_pkg.sv
package vit_pkg;

  // Trellis shape: code memory of K_LEN-1 bits, newest input bit in bit 0.
  localparam int K_LEN   = 7;
  localparam int NUM_ST  = 1 << (K_LEN - 1);
  localparam int HALF_ST = NUM_ST / 2;
  localparam int ST_W    = K_LEN - 1;

  // Generator taps over the register {state, input}.
  localparam logic [K_LEN-1:0] GEN0 = 7'o171;
  localparam logic [K_LEN-1:0] GEN1 = 7'o133;

  // Expected code bit pair {c0,c1} leaving predecessor state pred with input u.
  function automatic logic [1:0] exp_bits(input int unsigned pred, input logic u);
    logic [K_LEN-1:0] r;
    logic [ST_W-1:0]  p;
    p = pred[ST_W-1:0];
    r = {p, u};
    return {^(r & GEN0), ^(r & GEN1)};
  endfunction

endpackage

// File: rtl/vit_branch_unit.sv
// Forms the four possible branch costs of a stage, indexed by the expected
// bit pair {c0,c1}. All butterflies share these four values.
module vit_branch_unit #(
  parameter int SOFT_W = 4,
  localparam int BM_W  = SOFT_W + 1
) (
  input  logic signed [SOFT_W-1:0] sym0_i,
  input  logic signed [SOFT_W-1:0] sym1_i,
  output logic [3:0][BM_W-1:0]     cost_o
);

  localparam logic [SOFT_W-1:0] MAXC = '1;

  logic [SOFT_W-1:0] c0_zero, c0_one, c1_zero, c1_one;

  // Adding the half-range offset to a two's complement value flips its sign bit.
  assign c0_zero = {~sym0_i[SOFT_W-1], sym0_i[SOFT_W-2:0]};
  assign c1_zero = {~sym1_i[SOFT_W-1], sym1_i[SOFT_W-2:0]};
  assign c0_one  = MAXC - c0_zero;
  assign c1_one  = MAXC - c1_zero;

  for (genvar e = 0; e < 4; e++) begin : g_cost
    localparam bit EXP0 = ((e >> 1) & 1) == 1;
    localparam bit EXP1 = (e & 1) == 1;
    assign cost_o[e] = {1'b0, (EXP0 ? c0_one : c0_zero)}
                     + {1'b0, (EXP1 ? c1_one : c1_zero)};
  end

endmodule

// File: rtl/vit_butterfly.sv
// One radix-2 butterfly: predecessors i (lo) and i+HALF (hi) feed new states
// 2i (even) and 2i+1 (odd). Only the two costs a and b are needed.
module vit_butterfly #(
  parameter int PM_W = 10,
  parameter int BM_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_en_i,
  input  logic [PM_W-1:0] pm_lo_i,
  input  logic [PM_W-1:0] pm_hi_i,
  input  logic [BM_W-1:0] cost_b_i,
  input  logic [BM_W-1:0] cost_a_i,
  output logic [PM_W-1:0] pm_even_o,
  output logic [PM_W-1:0] pm_odd_o,
  output logic [1:0]      dec_o
);

  logic [PM_W:0] lo_b, hi_a, lo_a, hi_b;
  logic [PM_W:0] even_full, odd_full;
  logic          pick_even, pick_odd;

  always_comb begin
    lo_b = {1'b0, pm_lo_i} + {{(PM_W+1-BM_W){1'b0}}, cost_b_i};
    hi_a = {1'b0, pm_hi_i} + {{(PM_W+1-BM_W){1'b0}}, cost_a_i};
    lo_a = {1'b0, pm_lo_i} + {{(PM_W+1-BM_W){1'b0}}, cost_a_i};
    hi_b = {1'b0, pm_hi_i} + {{(PM_W+1-BM_W){1'b0}}, cost_b_i};
    // Strict compare: a tie keeps the lower predecessor.
    pick_even = hi_a < lo_b;
    pick_odd  = hi_b < lo_a;
    even_full = pick_even ? hi_a : lo_b;
    odd_full  = pick_odd  ? hi_b : lo_a;
  end

  assign pm_even_o = even_full[PM_W-1:0];
  assign pm_odd_o  = odd_full[PM_W-1:0];
  assign dec_o     = {pick_odd, pick_even};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_i |-> !even_full[PM_W] && !odd_full[PM_W]); // R5

endmodule

// File: rtl/vit_hist_mem.sv
// Survivor decision store: one word per stage, registered read port.
module vit_hist_mem #(
  parameter int DEPTH = 128,
  parameter int WORD_W = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= mem[raddr_i];
    end
  end

endmodule

// File: rtl/vit_min_finder.sv
// Returns the lowest index holding the smallest metric.
module vit_min_finder #(
  parameter int N    = 64,
  parameter int PM_W = 10,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0][PM_W-1:0] pm_i,
  output logic [IW-1:0]          idx_o
);

  logic [PM_W-1:0] best_val;

  always_comb begin
    best_val = pm_i[0];
    idx_o    = '0;
    for (int k = 1; k < N; k++) begin
      if (pm_i[k] < best_val) begin
        best_val = pm_i[k];
        idx_o    = IW'(k);
      end
    end
  end

endmodule

// File: rtl/vit_acs_core.sv
module vit_acs_core
  import vit_pkg::*;
#(
  parameter int SOFT_W     = 4,
  parameter int PM_W       = 10,
  parameter int HIST_DEPTH = 128,
  localparam int BM_W      = SOFT_W + 1,
  localparam int AW        = $clog2(HIST_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     sym_valid_i,
  input  logic                     last_i,
  input  logic signed [SOFT_W-1:0] sym0_i,
  input  logic signed [SOFT_W-1:0] sym1_i,
  input  logic [AW-1:0]            rd_addr_i,
  output logic [NUM_ST-1:0]        rd_data_o,
  input  logic [ST_W-1:0]          pm_sel_i,
  output logic [PM_W-1:0]          pm_o,
  output logic [ST_W-1:0]          best_state_o,
  output logic                     best_valid_o
);

  // ---------------- reset release synchroniser ----------------
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // ---------------- state ----------------
  logic [NUM_ST-1:0][PM_W-1:0] pm_q, pm_d, pm_new, pm_norm;
  logic [AW-1:0]               stage_q, stage_d;
  logic                        best_q, best_d;
  logic [NUM_ST-1:0]           dec_word;
  logic [NUM_ST-1:0]           new_msb, cur_msb;
  logic                        all_msb;
  logic                        step_en, pm_en;
  logic [3:0][BM_W-1:0]        cost;

  // A start in the same cycle wins over a presented symbol.
  assign step_en = sym_valid_i && !start_i;
  assign pm_en   = step_en || start_i;

  // ---------------- branch costs ----------------
  vit_branch_unit #(.SOFT_W(SOFT_W)) i_bmu (
    .sym0_i (sym0_i),
    .sym1_i (sym1_i),
    .cost_o (cost)
  );

  // ---------------- butterflies ----------------
  // Both generators tap the oldest and newest register bits, so flipping the
  // predecessor's top bit or the input complements the branch label: cost a
  // is the cost of the complemented label of b.
  for (genvar i = 0; i < HALF_ST; i++) begin : g_bfly
    localparam logic [1:0] EXP_B = exp_bits(i, 1'b0);
    localparam logic [1:0] EXP_A = ~EXP_B;
    logic [1:0] dec_pair;

    vit_butterfly #(.PM_W(PM_W), .BM_W(BM_W)) i_bfly (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .chk_en_i  (step_en),
      .pm_lo_i   (pm_q[i]),
      .pm_hi_i   (pm_q[i + HALF_ST]),
      .cost_b_i  (cost[EXP_B]),
      .cost_a_i  (cost[EXP_A]),
      .pm_even_o (pm_new[2*i]),
      .pm_odd_o  (pm_new[2*i + 1]),
      .dec_o     (dec_pair)
    );

    assign dec_word[2*i]     = dec_pair[0];
    assign dec_word[2*i + 1] = dec_pair[1];
  end

  // ---------------- renormalisation ----------------
  for (genvar j = 0; j < NUM_ST; j++) begin : g_msb
    assign new_msb[j] = pm_new[j][PM_W-1];
    assign cur_msb[j] = pm_q[j][PM_W-1];
    assign pm_norm[j] = all_msb ? {1'b0, pm_new[j][PM_W-2:0]} : pm_new[j];
  end
  assign all_msb = &new_msb;

  // ---------------- next state ----------------
  always_comb begin
    pm_d    = pm_q;
    stage_d = stage_q;
    best_d  = best_q;
    if (start_i) begin
      pm_d    = '0;
      stage_d = '0;
      best_d  = 1'b0;
    end else if (step_en) begin
      pm_d    = pm_norm;
      stage_d = stage_q + 1'b1;
      best_d  = last_i;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pm_q    <= '0;
      stage_q <= '0;
      best_q  <= 1'b0;
    end else if (pm_en) begin
      pm_q    <= pm_d;
      stage_q <= stage_d;
      best_q  <= best_d;
    end
  end

  // ---------------- history and outputs ----------------
  vit_hist_mem #(.DEPTH(HIST_DEPTH), .WORD_W(NUM_ST)) i_hist (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (step_en),
    .waddr_i (stage_q),
    .wdata_i (dec_word),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  vit_min_finder #(.N(NUM_ST), .PM_W(PM_W)) i_min (
    .pm_i  (pm_q),
    .idx_o (best_state_o)
  );

  assign pm_o         = pm_q[pm_sel_i];
  assign best_valid_o = best_q;

  // ---------------- assertions ----------------
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |=> (pm_q == '0) && (stage_q == '0) && !best_valid_o); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && !sym_valid_i) |=> $stable(pm_q) && $stable(stage_q) && $stable(best_valid_o)); // R6

  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en |=> stage_q == $past(stage_q) + 1'b1); // R7

  AST_NORM_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_en |=> !(&cur_msb)); // R5

  AST_BEST_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_en && last_i) |=> best_valid_o); // R8

endmodule

// File: tb/test_vit_acs_core.sv
module test_vit_acs_core;

  localparam int NS = 64;
  localparam int DEPTH = 128;
  localparam int WRAP = 24;

  // Each row: {seed[15:0], block length[7:0], noise amplitude[7:0]}
  localparam logic [31:0] CASES [5] = '{
    {16'h1a2b, 8'd48, 8'd0},
    {16'h3c4d, 8'd40, 8'd2},
    {16'h5e6f, 8'd64, 8'd4},
    {16'h7081, 8'd32, 8'd6},
    {16'h92a3, 8'd80, 8'd3}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start, valid, last;
  logic signed [3:0] sym0, sym1;
  logic [6:0]        rd_addr;
  logic [63:0]       rd_data;
  logic [5:0]        pm_sel;
  logic [9:0]        pm_val;
  logic [5:0]        best_state;
  logic              best_valid;

  always #5 clk = ~clk;

  vit_acs_core i_vit_acs_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .sym_valid_i  (valid),
    .last_i       (last),
    .sym0_i       (sym0),
    .sym1_i       (sym1),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .pm_sel_i     (pm_sel),
    .pm_o         (pm_val),
    .best_state_o (best_state),
    .best_valid_o (best_valid)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // ---------------- reference model ----------------
  int          ref_pm [NS];
  logic [63:0] ref_dec [DEPTH];
  int          ref_stage;
  int unsigned rnd_state;

  function automatic int unsigned rnd();
    rnd_state = rnd_state * 1103515245 + 12345;
    return (rnd_state >> 16) & 32'h7fff;
  endfunction

  function automatic int sym_cost(bit e, int s);
    return e ? (7 - s) : (s + 8);
  endfunction

  function automatic bit [1:0] enc_out(int st, bit u);
    bit [6:0] r;
    r = {st[5:0], u};
    return {^(r & 7'o171), ^(r & 7'o133)};
  endfunction

  task automatic ref_start();
    for (int j = 0; j < NS; j++) ref_pm[j] = 0;
    ref_stage = 0;
  endtask

  task automatic ref_step(int s0, int s1);
    int nw [NS];
    logic [63:0] d;
    bit all_hi;
    all_hi = 1'b1;
    for (int j = 0; j < NS; j++) begin
      int p0, p1, c0, c1;
      bit [1:0] e0, e1;
      p0 = j / 2;
      p1 = p0 + 32;
      e0 = enc_out(p0, j[0]);
      e1 = enc_out(p1, j[0]);
      c0 = ref_pm[p0] + sym_cost(e0[1], s0) + sym_cost(e0[0], s1);
      c1 = ref_pm[p1] + sym_cost(e1[1], s0) + sym_cost(e1[0], s1);
      d[j]  = (c1 < c0);
      nw[j] = (c1 < c0) ? c1 : c0;
      if (nw[j] < 512) all_hi = 1'b0;
    end
    for (int j = 0; j < NS; j++) ref_pm[j] = all_hi ? nw[j] - 512 : nw[j];
    ref_dec[ref_stage % DEPTH] = d;
    ref_stage++;
  endtask

  function automatic int ref_best();
    int b;
    b = 0;
    for (int j = 1; j < NS; j++) if (ref_pm[j] < ref_pm[b]) b = j;
    return b;
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_metrics(string req);
    int bad, first_j, first_a;
    bad = 0; first_j = 0; first_a = 0;
    for (int j = 0; j < NS; j++) begin
      pm_sel = j[5:0];
      #1;
      if (int'(pm_val) != ref_pm[j]) begin
        if (bad == 0) begin first_j = j; first_a = int'(pm_val); end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("metric of state %0d", first_j), first_a, ref_pm[first_j]);
  endtask

  task automatic check_hist(string req, int lo, int cnt);
    int bad, first_a;
    logic [63:0] got;
    bad = 0; first_a = lo; got = '0;
    for (int k = 0; k < cnt; k++) begin
      int a;
      a = (lo + k) % DEPTH;
      @(negedge clk) rd_addr = a[6:0];
      @(negedge clk);
      if (rd_data !== ref_dec[a]) begin
        if (bad == 0) begin first_a = a; got = rd_data; end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("decision word at %0d", first_a), longint'(got),
        longint'(ref_dec[first_a]));
  endtask

  // ---------------- drive helpers ----------------
  task automatic drive(int s0, int s1, bit lst);
    @(negedge clk);
    sym0 = s0[3:0]; sym1 = s1[3:0]; valid = 1'b1; last = lst;
    ref_step(s0, s1);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; last = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1; valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    ref_start();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    bit info [80];
    int sy0 [80];
    int sy1 [80];
    rst_n = 1'b0; start = 1'b0; valid = 1'b0; last = 1'b0;
    sym0 = '0; sym1 = '0; rd_addr = '0; pm_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    ref_start();
    chk(best_valid == 1'b0, "R1", "best_valid after reset", best_valid, 0);
    check_metrics("R1");

    // Table-driven tail-biting blocks (R3, R4, R7, R8, R9)
    for (int r = 0; r < 5; r++) begin
      int n, amp, st, tstate, total, idx;
      rnd_state = {16'h0, CASES[r][31:16]};
      n   = int'(CASES[r][15:8]);
      amp = int'(CASES[r][7:0]);
      for (int k = 0; k < n; k++) info[k] = rnd() & 1;
      st = 0;
      for (int k = n - 6; k < n; k++) st = ((st << 1) | info[k]) & 63;
      for (int k = 0; k < n; k++) begin
        bit [1:0] c;
        int v0, v1;
        c = enc_out(st, info[k]);
        st = ((st << 1) | info[k]) & 63;
        v0 = (c[1] ? 6 : -6) + int'(rnd() % (2 * amp + 1)) - amp;
        v1 = (c[0] ? 6 : -6) + int'(rnd() % (2 * amp + 1)) - amp;
        sy0[k] = (v0 > 7) ? 7 : (v0 < -8) ? -8 : v0;
        sy1[k] = (v1 > 7) ? 7 : (v1 < -8) ? -8 : v1;
      end
      tstate = 0;
      for (int k = 0; k < WRAP; k++) tstate = ((tstate << 1) | info[k]) & 63;

      do_start();
      total = n + 2 * WRAP;
      for (int k = 0; k < total; k++) begin
        idx = (k < WRAP) ? (n - WRAP + k) : (k < WRAP + n) ? (k - WRAP) : (k - WRAP - n);
        drive(sy0[idx], sy1[idx], k == total - 1);
      end
      idle();
      chk(best_valid == 1'b1, "R8", "best_valid after last stage", best_valid, 1);
      chk(int'(best_state) == ref_best(), "R8", "best state", best_state, ref_best());
      check_metrics("R4");
      check_hist("R3", 0, total);
      if (amp == 0)
        chk(int'(best_state) == tstate, "R9", "tail-biting end state", best_state, tstate);
    end

    // R6: idle cycles change nothing
    repeat (6) @(negedge clk);
    check_metrics("R6");
    chk(best_valid == 1'b1, "R6", "best_valid held while idle", best_valid, 1);

    // R7/R8: one more stage without last lands at the next address and drops the flag
    drive(3, -5, 1'b0);
    idle();
    chk(best_valid == 1'b0, "R8", "best_valid after non-last stage", best_valid, 0);
    check_hist("R7", ref_stage - 1, 1);

    // R2: start wins over a simultaneous symbol
    @(negedge clk);
    start = 1'b1; valid = 1'b1; sym0 = 4'sd7; sym1 = 4'sd7;
    @(negedge clk);
    start = 1'b0; valid = 1'b0;
    ref_start();
    check_metrics("R2");
    chk(best_valid == 1'b0, "R2", "best_valid after start", best_valid, 0);
    drive(-4, 2, 1'b1);
    idle();
    check_hist("R2", 0, 1);

    // R5/R7: neutral symbols force renormalisation and address wrap
    do_start();
    for (int k = 0; k < 140; k++) drive(0, 0, k == 139);
    idle();
    check_metrics("R5");
    chk(int'(best_state) == ref_best(), "R5", "best state after renormalisation",
        best_state, ref_best());
    check_hist("R7", 0, 12);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule